// File: doc/BRIEF.md
# Serial Display Link Clock-Lane Sequencer

This block sequences the clock lane of a serial display link host and chooses the signalling mode of the data lanes for each packet. Two controls drive it, and they are independent of each other. A clock-mode bit selects how the clock lane idles: with 0 the high-speed (HS) clock runs for as long as the link is enabled, and with 1 the clock runs only around HS bursts. A per-packet speed flag selects the data-lane mode: 1 means high-speed and 0 means low-power (LP). The block never stops the HS clock because a packet is sent in low-power mode.

A byte-level packet source raises a request together with the speed flag. The block acknowledges the request with a one-cycle grant and then opens a byte gate, through which the source streams bytes up to one marked last. In transmit-only mode a high-speed request first starts the clock. The block then holds off the data lanes for a programmable prepare count. After the last byte it keeps the clock running for a programmable trail count before returning the clock lane to LP-11. A further HS request that arrives inside the trail window reuses the running clock. The clock-mode bit is sampled only while the block is idle, so a change never takes effect in the middle of a packet.

Top module: `dsl_clklane_ctrl`

## Requirements
- R1: While reset is held (synchronous, active-low), busy=0, clk_running=0, clk_lp11=1, lane_hs=0 and src_ready=0.
- R2: With link_en=1 and cfg_clk_mode=0 (continuous), clk_running rises on the second rising edge after reset is released. It then never falls while link_en stays 1, including across HS and LP packets.
- R3: With cfg_clk_mode=1 (transmit-only) and no packet in progress, clk_running=0 and clk_lp11=1.
- R4: In transmit-only mode, an HS request (pkt_hs=1) that is granted while the clock is stopped raises clk_running on the grant edge. src_ready and lane_hs rise exactly prep_cnt+1 cycles after that edge.
- R5: In transmit-only mode, after the last HS byte is taken, lane_hs drops at once. clk_running stays high for trail_cnt+1 cycles and then falls, and busy falls with it.
- R6: An HS request made during the trail window is granted at once. Bytes are accepted on the next cycle with no prepare wait, and the clock does not stop in between.
- R7: An LP request (pkt_hs=0) in transmit-only mode is served with clk_running=0 and lane_hs=0 throughout. Bytes are accepted on the cycle after the grant.
- R8: An LP request in continuous mode is served with clk_running=1 and lane_hs=0. Bytes are accepted on the cycle after the grant.
- R9: An HS request in continuous mode is served with no prepare wait (bytes on the cycle after the grant) and lane_hs=1. After the last byte the block goes idle at once.
- R10: A change of cfg_clk_mode while a packet is in progress is ignored until the block is idle again. A packet that started in continuous mode ends with no trail window, and the clock stops two cycles after it ends.
- R11: pkt_ack is high for exactly one cycle per granted request. src_ready is high only while bytes are being taken. While src_ready=1, lane_valid and lane_data follow src_valid and src_data.
- R12: With link_en=0 the clock is stopped within one cycle and no request is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_en | input | 1 | Link enable |
| cfg_clk_mode | input | 1 | Clock-lane mode: 0 continuous, 1 transmit-only |
| prep_cnt | input | CNT_W | Clock prepare count before HS data |
| trail_cnt | input | CNT_W | Clock trail count after the last HS byte |
| pkt_req | input | 1 | Packet request, held until granted |
| pkt_hs | input | 1 | Packet speed: 1 high-speed, 0 low-power |
| pkt_ack | output | 1 | One-cycle grant of the request |
| src_valid | input | 1 | Source byte valid |
| src_data | input | DATA_W | Source byte |
| src_last | input | 1 | Marks the final byte of the packet |
| src_ready | output | 1 | Byte gate open |
| lane_valid | output | 1 | Byte presented to the data lanes |
| lane_data | output | DATA_W | Byte to the data lanes |
| lane_hs | output | 1 | Data-lane mode: 1 HS, 0 LP |
| clk_running | output | 1 | HS clock running on the clock lane |
| clk_lp11 | output | 1 | Clock lane resting in LP-11 |
| busy | output | 1 | A packet or its trail window is in progress |

## Verification
A wrong sequencer state shows at the ports within one cycle. A stale mode latch makes clk_running fall in continuous mode, or keeps it high past trail_cnt+1 cycles. A prepare counter that is off by one shifts the first src_ready by a measurable cycle count from the grant. A missed trail transition makes busy drop early, or forces a second prepare wait in the back-to-back case. The bench measures these distances in cycles for each mode and speed pair, and it checks that the clock never falls in continuous mode.

// File: rtl/dsl_clk_pkg.sv
// Shared types for the clock-lane sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dsl_clk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PREP  = 2'd1,
        ST_SEND  = 2'd2,
        ST_TRAIL = 2'd3
    } lane_st_e;
endpackage

// File: rtl/dsl_settle_timer.sv
// Down-counter for clock prepare and trail windows.
// Loading value N and then running gives N+1 cycles before done is seen.
// Assumes: load and run are never needed in the same cycle for two windows.
module dsl_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Count down toward zero while a window is open; reload on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/dsl_lane_seq.sv
// Clock-lane and data-lane mode sequencer.
// Holds the latched clock mode, the HS clock state, the packet speed and
// the phase (idle, prepare, send, trail).
// Assumes: the source holds req and req_hs until the grant; bytes end with src_last.
module dsl_lane_seq
    import dsl_clk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             link_en,
    input  logic             cfg_tx_only,
    input  logic             req,
    input  logic             req_hs,
    input  logic             src_valid,
    input  logic             src_last,
    input  logic [CNT_W-1:0] prep_cnt,
    input  logic [CNT_W-1:0] trail_cnt,
    output logic             pkt_ack,
    output logic             src_ready,
    output logic             lane_hs,
    output logic             clk_on,
    output logic             busy
);
    lane_st_e         state_q, state_d;
    logic             clk_on_q, clk_on_d;
    logic             tx_only_q, tx_only_d;
    logic             hs_q, hs_d;
    logic             acc_idle, acc_trail, end_pkt;
    logic             tmr_load, tmr_done, tmr_run;
    logic [CNT_W-1:0] tmr_val;

    // Grant decisions and end of packet.
    always_comb begin
        acc_idle  = link_en && req && (state_q == ST_IDLE);
        acc_trail = link_en && req && req_hs && (state_q == ST_TRAIL);
        end_pkt   = (state_q == ST_SEND) && src_valid && src_last;
    end

    // Next phase, clock state, mode latch and timer loads.
    always_comb begin
        state_d   = state_q;
        clk_on_d  = clk_on_q;
        tx_only_d = tx_only_q;
        hs_d      = hs_q;
        tmr_load  = 1'b0;
        tmr_val   = prep_cnt;
        if (!link_en) begin
            state_d   = ST_IDLE;
            clk_on_d  = 1'b0;
            tx_only_d = cfg_tx_only;
            hs_d      = 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    clk_on_d = !tx_only_q || (acc_idle && req_hs);
                    if (acc_idle) begin
                        hs_d = req_hs;
                        if (req_hs && !clk_on_q) begin
                            state_d  = ST_PREP;
                            tmr_load = 1'b1;
                        end else begin
                            state_d = ST_SEND;
                        end
                    end else begin
                        tx_only_d = cfg_tx_only;
                    end
                end
                ST_PREP: begin
                    if (tmr_done)
                        state_d = ST_SEND;
                end
                ST_SEND: begin
                    if (end_pkt) begin
                        if (hs_q && tx_only_q) begin
                            state_d  = ST_TRAIL;
                            tmr_load = 1'b1;
                            tmr_val  = trail_cnt;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (acc_trail) begin
                        state_d = ST_SEND;
                        hs_d    = 1'b1;
                    end else if (tmr_done) begin
                        state_d  = ST_IDLE;
                        clk_on_d = 1'b0;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State registers; transmit-only is the safe mode out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            clk_on_q  <= 1'b0;
            tx_only_q <= 1'b1;
            hs_q      <= 1'b0;
        end else begin
            state_q   <= state_d;
            clk_on_q  <= clk_on_d;
            tx_only_q <= tx_only_d;
            hs_q      <= hs_d;
        end
    end

    assign tmr_run = (state_q == ST_PREP) || (state_q == ST_TRAIL);

    dsl_settle_timer #(.CNT_W(CNT_W)) i_settle_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .done     (tmr_done)
    );

    // Port view of the sequencer state.
    assign pkt_ack   = acc_idle || acc_trail;
    assign src_ready = (state_q == ST_SEND);
    assign lane_hs   = src_ready && hs_q;
    assign clk_on    = clk_on_q;
    assign busy      = (state_q != ST_IDLE);

    // R2
    cont_clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_on_q) |-> ($past(tx_only_q) || !$past(link_en)));

    // R4
    hs_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_hs |-> clk_on_q);

    // R10
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(tx_only_q));

    // R11
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ack |=> !pkt_ack);

    // R3
    txonly_idle_lp11_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && $past(state_q == ST_IDLE) && tx_only_q && $past(tx_only_q))
        |-> !clk_on_q);

    // R7
    lp_keeps_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready && !hs_q && tx_only_q) |-> !clk_on_q);
endmodule

// File: rtl/dsl_byte_gate.sv
// Byte gate between the packet source and the data lanes.
// Passes bytes through only while the sequencer has the gate open.
// Assumes: the downstream lane logic takes a byte in every cycle it is valid.
module dsl_byte_gate #(
    parameter int DATA_W = 8
) (
    input  logic              gate_open,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              lane_valid,
    output logic [DATA_W-1:0] lane_data
);
    // Forward the byte when open; hold the lanes quiet otherwise.
    always_comb begin
        lane_valid = gate_open && src_valid;
        lane_data  = gate_open ? src_data : '0;
    end
endmodule

// File: rtl/dsl_clklane_ctrl.sv
// Top of the clock-lane controller: sequencer plus byte gate.
// Assumes: cfg_clk_mode and the settle counts come from a control register
// owned elsewhere; the counts stay stable while a window is open.
module dsl_clklane_ctrl #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_en,
    input  logic              cfg_clk_mode,
    input  logic [CNT_W-1:0]  prep_cnt,
    input  logic [CNT_W-1:0]  trail_cnt,
    input  logic              pkt_req,
    input  logic              pkt_hs,
    output logic              pkt_ack,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_last,
    output logic              src_ready,
    output logic              lane_valid,
    output logic [DATA_W-1:0] lane_data,
    output logic              lane_hs,
    output logic              clk_running,
    output logic              clk_lp11,
    output logic              busy
);
    logic clk_on;

    dsl_lane_seq #(.CNT_W(CNT_W)) i_lane_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_en     (link_en),
        .cfg_tx_only (cfg_clk_mode),
        .req         (pkt_req),
        .req_hs      (pkt_hs),
        .src_valid   (src_valid),
        .src_last    (src_last),
        .prep_cnt    (prep_cnt),
        .trail_cnt   (trail_cnt),
        .pkt_ack     (pkt_ack),
        .src_ready   (src_ready),
        .lane_hs     (lane_hs),
        .clk_on      (clk_on),
        .busy        (busy)
    );

    dsl_byte_gate #(.DATA_W(DATA_W)) i_byte_gate (
        .gate_open  (src_ready),
        .src_valid  (src_valid),
        .src_data   (src_data),
        .lane_valid (lane_valid),
        .lane_data  (lane_data)
    );

    // The clock lane is in LP-11 exactly when the HS clock is stopped.
    assign clk_running = clk_on;
    assign clk_lp11    = !clk_on;
endmodule

// File: tb/test_dsl_clklane_ctrl.sv
module test_dsl_clklane_ctrl;
    logic       clk = 1'b0;
    logic       rst_n, link_en, cfg_clk_mode, pkt_req, pkt_hs;
    logic       src_valid, src_last;
    logic [7:0] src_data, prep_cnt, trail_cnt;
    logic       pkt_ack, src_ready, lane_valid, lane_hs, clk_running, clk_lp11, busy;
    logic [7:0] lane_data;
    int         total = 0;
    int         bad = 0;
    int         cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dsl_clklane_ctrl i_dsl_clklane_ctrl (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .cfg_clk_mode(cfg_clk_mode),
        .prep_cnt(prep_cnt), .trail_cnt(trail_cnt), .pkt_req(pkt_req), .pkt_hs(pkt_hs),
        .pkt_ack(pkt_ack), .src_valid(src_valid), .src_data(src_data), .src_last(src_last),
        .src_ready(src_ready), .lane_valid(lane_valid), .lane_data(lane_data),
        .lane_hs(lane_hs), .clk_running(clk_running), .clk_lp11(clk_lp11), .busy(busy)
    );

    typedef struct packed {
        logic [7:0] mode, hs, prep, trail, nb, lat, on_cnt;
    } vec_t;
    // mode, hs, prep, trail, bytes, cycles grant->src_ready, clock-on samples after last byte (cap 40)
    localparam int NV = 6;
    localparam vec_t VT [NV] = '{
        '{8'd1, 8'd1, 8'd3, 8'd2, 8'd4, 8'd5, 8'd3},
        '{8'd1, 8'd1, 8'd0, 8'd0, 8'd1, 8'd2, 8'd1},
        '{8'd1, 8'd0, 8'd3, 8'd2, 8'd3, 8'd1, 8'd0},
        '{8'd0, 8'd1, 8'd3, 8'd2, 8'd3, 8'd1, 8'd40},
        '{8'd0, 8'd0, 8'd5, 8'd5, 8'd2, 8'd1, 8'd40},
        '{8'd1, 8'd1, 8'd7, 8'd9, 8'd2, 8'd9, 8'd10}
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Stream n bytes starting at a sample point with src_ready high; ends at sample j=1 after the last.
    task automatic send_bytes(input int n, input int hs, input int clk_exp, input string tag);
        for (int i = 0; i < n; i++) begin
            src_valid = 1'b1;
            src_data  = 8'h30 + 8'(i * 7);
            src_last  = (i == n - 1);
            #1;
            chk({tag, " R11 lane_valid"}, int'(lane_valid), 1);
            chk({tag, " R11 lane_data"}, int'(lane_data), int'(src_data));
            chk({tag, " lane_hs"}, int'(lane_hs), hs);
            chk({tag, " clk during bytes"}, int'(clk_running), clk_exp);
            @(negedge clk);
        end
        src_valid = 1'b0;
        src_last  = 1'b0;
    endtask

    task automatic grant(input int hs, input string tag);
        pkt_req = 1'b1;
        pkt_hs  = hs[0];
        #1;
        chk({tag, " R11 ack on request"}, int'(pkt_ack), 1);
        @(negedge clk);
        chk({tag, " R11 single ack"}, int'(pkt_ack), 0);
        pkt_req = 1'b0;
    endtask

    initial begin
        wait (cyc > 20000);
        bad++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat, on, c1;
        rst_n = 1'b0; link_en = 1'b1; cfg_clk_mode = 1'b0; pkt_req = 1'b0; pkt_hs = 1'b0;
        src_valid = 1'b0; src_last = 1'b0; src_data = '0; prep_cnt = 8'd2; trail_cnt = 8'd2;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 clk_running", int'(clk_running), 0);
        chk("R1 clk_lp11", int'(clk_lp11), 1);
        chk("R1 lane_hs", int'(lane_hs), 0);
        chk("R1 src_ready", int'(src_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 clk after first edge", int'(clk_running), 0);
        @(negedge clk);
        chk("R2 clk after second edge", int'(clk_running), 1);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            string tl, to;
            tl = (VT[v].hs != 0) ? ((VT[v].mode != 0) ? "R4" : "R9") : ((VT[v].mode != 0) ? "R7" : "R8");
            to = (VT[v].hs != 0) ? ((VT[v].mode != 0) ? "R5" : "R2") : ((VT[v].mode != 0) ? "R7" : "R8");
            cfg_clk_mode = VT[v].mode[0];
            prep_cnt = VT[v].prep;
            trail_cnt = VT[v].trail;
            repeat (5) @(negedge clk);
            chk((VT[v].mode != 0) ? "R3 idle clock" : "R2 idle clock", int'(clk_running), (VT[v].mode != 0) ? 0 : 1);
            chk((VT[v].mode != 0) ? "R3 idle lp11" : "R2 idle lp11", int'(clk_lp11), int'(VT[v].mode));
            chk("R11 src_ready idle", int'(src_ready), 0);
            grant(int'(VT[v].hs), tl);
            c1 = int'(clk_running);
            lat = 1;
            while (!src_ready && lat < 50) begin
                @(negedge clk);
                lat++;
            end
            chk({tl, " grant to bytes"}, lat, int'(VT[v].lat));
            chk({tl, " clock after grant"}, c1, (VT[v].hs != 0 || VT[v].mode == 0) ? 1 : 0);
            send_bytes(int'(VT[v].nb), int'(VT[v].hs), (VT[v].hs != 0 || VT[v].mode == 0) ? 1 : 0, tl);
            chk({to, " lane_hs after last"}, int'(lane_hs), 0);
            on = 0;
            while (clk_running && on < 40) begin
                on++;
                @(negedge clk);
            end
            chk({to, " clock-on after last"}, on, int'(VT[v].on_cnt));
            if (on < 40) chk({to, " busy after trail"}, int'(busy), 0);
        end

        // R6 back-to-back HS inside the trail window
        cfg_clk_mode = 1'b1; prep_cnt = 8'd4; trail_cnt = 8'd6;
        repeat (5) @(negedge clk);
        grant(1, "R6");
        while (!src_ready) @(negedge clk);
        send_bytes(2, 1, 1, "R6");
        @(negedge clk);
        @(negedge clk);
        chk("R6 clock in trail", int'(clk_running), 1);
        grant(1, "R6");
        chk("R6 no prepare wait", int'(src_ready), 1);
        chk("R6 clock kept", int'(clk_running), 1);
        chk("R6 lane_hs", int'(lane_hs), 1);
        send_bytes(1, 1, 1, "R6");
        on = 0;
        while (clk_running && on < 40) begin
            on++;
            @(negedge clk);
        end
        chk("R5 R6 second trail", on, 7);

        // R10 mode change during a packet waits for idle
        cfg_clk_mode = 1'b0; prep_cnt = 8'd3; trail_cnt = 8'd3;
        repeat (5) @(negedge clk);
        grant(1, "R10");
        chk("R10 bytes at once", int'(src_ready), 1);
        cfg_clk_mode = 1'b1;
        send_bytes(3, 1, 1, "R10");
        chk("R10 no trail window", int'(busy), 0);
        chk("R10 clock j1", int'(clk_running), 1);
        @(negedge clk);
        chk("R10 clock j2", int'(clk_running), 1);
        @(negedge clk);
        chk("R10 clock stopped j3", int'(clk_running), 0);
        chk("R10 lp11 j3", int'(clk_lp11), 1);

        // R12 link disable
        cfg_clk_mode = 1'b0;
        repeat (5) @(negedge clk);
        chk("R12 clock before disable", int'(clk_running), 1);
        link_en = 1'b0;
        @(negedge clk);
        chk("R12 clock stopped", int'(clk_running), 0);
        pkt_req = 1'b1; pkt_hs = 1'b1;
        #1;
        chk("R12 no grant", int'(pkt_ack), 0);
        @(negedge clk);
        chk("R12 not busy", int'(busy), 0);
        pkt_req = 1'b0;
        link_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 clock back", int'(clk_running), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule